// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block timestamps edges on two external signals. A free-running down counter supplies the time base. Each of two capture channels watches one input pin through a synchronizer and reacts to either the rising or the falling edge, as software chooses. On an active edge the channel copies the counter into its own read-only capture register and raises a flag. When a further active edge arrives before software has acknowledged the flag, the channel raises an overrun error instead and keeps the value it already holds.

Software reaches the block through a small register port with four addresses: two capture registers, a status register whose bits are cleared by writing ones, and a control register. The control register holds the two polarity bits and five interrupt enables. Flags also exist for the counter reaching zero, for the counter wrapping, and for an external compare event. A single interrupt line is high while any flag is set and its enable is on.

The channels can be used together for several measurements. If both channels watch the same pin with opposite polarities, the two captures give a pulse width. Two edges captured on one channel give a period. If the channels watch different pins with the same polarity, the order in which their flags rise gives the phase.

Top module: `cap_timer`

## Requirements
- R1: The counter holds 16'hFFFF in reset, falls by one on every clock and goes from 0 back to 16'hFFFF without stopping.
- R2: Control bit 0 selects the active edge of `cap_pin_a` and control bit 1 the active edge of `cap_pin_b`, with 1 for rising and 0 for falling. An edge of the other direction changes no capture and no flag.
- R3: An active edge on `cap_pin_a` loads the counter into the register at address 0, and one on `cap_pin_b` loads the register at address 1. The value loaded is the counter value present when the pin changed, minus 2, which is the synchronizer delay. The capture also sets that channel's flag.
- R4: An active edge that arrives while the channel's flag or error bit is set sets the error bit and leaves the capture register unchanged.
- R5: The two channels act independently. An edge on one pin never changes the other channel's capture, flag or error bit.
- R6: Writes to addresses 0 and 1 have no effect on the capture registers.
- R7: Address 2 is status. Bit 0 is the A flag, bit 1 the A error, bit 2 the B flag, bit 3 the B error, bit 4 overflow, bit 5 compare and bit 6 zero. Writing 1 to a bit clears it. An event in the same cycle as the clear wins and leaves the bit set.
- R8: The zero flag sets on the clock edge at which the counter becomes 0. The overflow flag sets on the next edge, when the counter becomes 16'hFFFF. The compare flag sets on a one-cycle pulse of `cmp_evt`.
- R9: Flags set whatever the state of the enables. With all enables at 0, `irq` stays low.
- R10: Address 3 is control, and its bits 2 to 6 enable A, B, overflow, compare and zero in that order. `irq` is the OR of each flag ANDed with its enable. It rises in the cycle after an enable is written to 1 over a flag that is already set.
- R11: After reset, status, control and both captures read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_pin_a | input | 1 | Asynchronous capture input, channel A |
| cap_pin_b | input | 1 | Asynchronous capture input, channel B |
| cmp_evt | input | 1 | One-cycle compare event pulse |
| reg_addr | input | 2 | Register select: 0 capture A, 1 capture B, 2 status, 3 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 7 | Write data |
| reg_rdata | output | CNT_W (16) | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the overrun rule. It sends a second active edge while the flag is still up. A design that overwrote the capture on that edge would return a newer value, and one that did not latch the error would report a clean status. It also pulses a compare event in the same cycle as the write that clears the compare flag. A design that gave the clear priority would lose the event.

Inactive edges are driven to catch a polarity mix-up, which would show up as spurious flags. A capture is taken across the counter wrap to expose an off-by-one or a stuck reload. Period and pulse-width spans are measured from two captures, so a counter that skips cycles or a wrong synchronizer depth would give wrong differences. Enables are written after their flags are already set to catch an interrupt line that only responds to new events.

// File: rtl/cap_timer_pkg.sv
// Shared constants for the capture timer: register selects and bit
// positions in the status and control registers.
package cap_timer_pkg;

    typedef enum logic [1:0] {
        REG_CAP_A  = 2'd0,
        REG_CAP_B  = 2'd1,
        REG_STATUS = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    // Status bits (write 1 to clear); per-channel pairs are {err, flag}
    localparam int ST_A_FLAG = 0;
    localparam int ST_A_ERR  = 1;
    localparam int ST_B_FLAG = 2;
    localparam int ST_B_ERR  = 3;
    localparam int ST_OVF    = 4;
    localparam int ST_CMP    = 5;
    localparam int ST_ZERO   = 6;
    localparam int ST_BITS   = 7;

    // Control bits; enables sit in the same order as the status sources
    localparam int CT_POL_A   = 0;
    localparam int CT_POL_B   = 1;
    localparam int CT_IE_A    = 2;
    localparam int CT_IE_B    = 3;
    localparam int CT_IE_OVF  = 4;
    localparam int CT_IE_CMP  = 5;
    localparam int CT_IE_ZERO = 6;
    localparam int CT_BITS    = 7;

    localparam int NUM_CH   = 2;
    localparam int NUM_IRQ  = 5;
    localparam int WDATA_W  = (ST_BITS > CT_BITS) ? ST_BITS : CT_BITS;

endpackage

// File: rtl/cap_free_counter.sv
// Free-running down counter that forms the capture time base.
// Assumes: reloads all-ones on reset and after reaching zero; never stops.
// Emits a pulse in the cycle before it becomes zero and in the cycle it wraps.
module cap_free_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_q,
    output logic         zero_evt,
    output logic         wrap_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    // Decrement each clock; natural modular wrap reloads all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_q - ONE;
    end

    assign zero_evt = (cnt_q == ONE);
    assign wrap_evt = (cnt_q == '0);

    assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
    assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |=> (cnt_q == '1));

endmodule

// File: rtl/cap_edge_det.sv
// Brings one asynchronous pin into the clock domain and flags its active edge.
// Assumes: SYNC_STAGES >= 2; rise_sel = 1 picks rising, 0 picks falling.
// act_edge is high for one cycle, SYNC_STAGES edges after the pin changes.
module cap_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic rise_sel,
    output logic act_edge
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    // Synchronizer chain plus one history flop for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin_in};
            prev_q <= sync_q[MSB];
        end
    end

    assign act_edge = rise_sel ? (sync_q[MSB] & ~prev_q) : (~sync_q[MSB] & prev_q);

    assert_edge_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> !act_edge);

endmodule

// File: rtl/cap_channel.sv
// One capture channel: capture register, capture flag and overrun error.
// Assumes: act_edge is a single-cycle strobe; clears are write-1 strobes.
// A capture happens only while flag and error are both clear.
module cap_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act_edge,
    input  logic [W-1:0] cnt,
    input  logic         clr_flag,
    input  logic         clr_err,
    output logic [W-1:0] cap_q,
    output logic         flag_q,
    output logic         err_q
);
    logic take;
    logic overrun;

    assign take    = act_edge & ~flag_q & ~err_q;
    assign overrun = act_edge & (flag_q | err_q);

    // Capture register loads only on an accepted edge
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (take) cap_q <= cnt;
    end

    // Flag: event has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (take)     flag_q <= 1'b1;
        else if (clr_flag) flag_q <= 1'b0;
    end

    // Error: set by an edge that arrives before acknowledgement
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (overrun) err_q <= 1'b1;
        else if (clr_err) err_q <= 1'b0;
    end

    assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_edge && !flag_q && !err_q) |=> (flag_q && cap_q == $past(cnt)));
    assert_overrun_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_edge && (flag_q || err_q)) |=> (err_q && $stable(cap_q)));
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_edge && clr_flag && flag_q) |=> !flag_q);

endmodule

// File: rtl/cap_timer.sv
// Dual-channel input capture timer with register port and combined interrupt.
// Assumes: CNT_W > status width; reads are combinational; writes take
// effect at the next clock edge. Status bits clear on write-1.
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_pin_a,
    input  logic               cap_pin_b,
    input  logic               cmp_evt,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               irq
);
    localparam int ST_PAD = CNT_W - ST_BITS;
    localparam int CT_PAD = CNT_W - CT_BITS;

    logic [CNT_W-1:0]   cnt;
    logic               zero_evt, wrap_evt;
    logic [CT_BITS-1:0] ctrl_q;
    logic [ST_BITS-1:0] clr_v;
    logic [ST_BITS-1:0] status_v;
    logic               ovf_q, cmp_q, zero_q;
    logic [NUM_CH-1:0]  pin_v, edge_v, flag_v, err_v;
    logic [CNT_W-1:0]   cap_v [NUM_CH];
    logic [NUM_IRQ-1:0] src_v, en_v;

    cap_free_counter #(.W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt),
        .zero_evt (zero_evt),
        .wrap_evt (wrap_evt)
    );

    assign pin_v = {cap_pin_b, cap_pin_a};
    assign clr_v = (reg_wr && reg_addr == REG_STATUS) ? reg_wdata[ST_BITS-1:0] : '0;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (pin_v[ch]),
            .rise_sel (ctrl_q[CT_POL_A + ch]),
            .act_edge (edge_v[ch])
        );
        cap_channel #(.W(CNT_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_edge (edge_v[ch]),
            .cnt      (cnt),
            .clr_flag (clr_v[ST_A_FLAG + 2*ch]),
            .clr_err  (clr_v[ST_A_ERR + 2*ch]),
            .cap_q    (cap_v[ch]),
            .flag_q   (flag_v[ch]),
            .err_q    (err_v[ch])
        );
    end

    // Control register: polarity and interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (reg_wr && reg_addr == REG_CTRL) ctrl_q <= reg_wdata[CT_BITS-1:0];
    end

    // Counter and compare flags: event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            cmp_q  <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            ovf_q  <= wrap_evt | (ovf_q  & ~clr_v[ST_OVF]);
            cmp_q  <= cmp_evt  | (cmp_q  & ~clr_v[ST_CMP]);
            zero_q <= zero_evt | (zero_q & ~clr_v[ST_ZERO]);
        end
    end

    // Status vector assembled in register bit order
    always_comb begin
        status_v            = '0;
        status_v[ST_A_FLAG] = flag_v[0];
        status_v[ST_A_ERR]  = err_v[0];
        status_v[ST_B_FLAG] = flag_v[1];
        status_v[ST_B_ERR]  = err_v[1];
        status_v[ST_OVF]    = ovf_q;
        status_v[ST_CMP]    = cmp_q;
        status_v[ST_ZERO]   = zero_q;
    end

    // Interrupt: any enabled source
    assign src_v = {zero_q, cmp_q, ovf_q, flag_v[1], flag_v[0]};
    assign en_v  = ctrl_q[CT_IE_ZERO:CT_IE_A];
    assign irq   = |(src_v & en_v);

    // Read mux
    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_CAP_A:  reg_rdata = cap_v[0];
            REG_CAP_B:  reg_rdata = cap_v[1];
            REG_STATUS: reg_rdata = {{ST_PAD{1'b0}}, status_v};
            default:    reg_rdata = {{CT_PAD{1'b0}}, ctrl_q};
        endcase
    end

    assert_cap_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_CAP_A && !edge_v[0]) |=> $stable(cap_v[0]));
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> zero_q);
    assert_ovf_after_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> ovf_q);
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CT_IE_ZERO:CT_IE_A] == '0) |-> !irq);
    assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v[0] && ctrl_q[CT_IE_A]) |-> irq);
    assert_chan_independent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_v[1] && !clr_v[ST_B_FLAG]) |=> $stable(cap_v[1]) && (flag_v[1] || !$past(flag_v[1])));

endmodule

// File: tb/test_cap_timer.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for the counter wrap and a mid-run reset.
module test_cap_timer;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_PIN  = 3'd1;
    localparam logic [2:0] OP_IDLE = 3'd2;
    localparam logic [2:0] OP_CHK  = 3'd3;
    localparam logic [2:0] OP_CAP  = 3'd4;
    localparam logic [2:0] OP_SPAN = 3'd5;
    localparam logic [2:0] OP_IRQ  = 3'd6;
    localparam logic [2:0] OP_CMP  = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  arg;
        logic [3:0]  req;
        logic [15:0] val;
    } vec_t;

    // PIN val: bit0 pin A, bit1 pin B, bit2 record A time, bit3 record B time
    localparam int NV = 63;
    localparam vec_t VECS [NV] = '{
        '{OP_CHK,  2'd2, 4'd11, 16'h0000},  // R11 status after reset
        '{OP_WR,   2'd3, 4'd2,  16'h0003},  // R2 both rising
        '{OP_PIN,  2'd0, 4'd3,  16'h0005},
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_CHK,  2'd2, 4'd3,  16'h0001},  // R3 flag A only
        '{OP_CAP,  2'd0, 4'd3,  16'h0000},  // R3 capture value
        '{OP_PIN,  2'd0, 4'd2,  16'h0000},  // falling edge, inactive
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_CHK,  2'd2, 4'd2,  16'h0001},  // R2 no error from inactive edge
        '{OP_PIN,  2'd0, 4'd4,  16'h0001},  // second active edge
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_CHK,  2'd2, 4'd4,  16'h0003},  // R4 error set
        '{OP_CAP,  2'd0, 4'd4,  16'h0000},  // R4 capture held
        '{OP_WR,   2'd0, 4'd6,  16'h0055},
        '{OP_CAP,  2'd0, 4'd6,  16'h0000},  // R6 write ignored
        '{OP_WR,   2'd2, 4'd7,  16'h0003},
        '{OP_CHK,  2'd2, 4'd7,  16'h0000},  // R7 write-1 clear
        '{OP_PIN,  2'd0, 4'd0,  16'h0000},
        '{OP_IDLE, 2'd0, 4'd0,  16'd3},
        '{OP_PIN,  2'd0, 4'd3,  16'h0005},
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_CAP,  2'd0, 4'd3,  16'h0000},  // R3 first period edge
        '{OP_WR,   2'd2, 4'd7,  16'h0001},
        '{OP_PIN,  2'd0, 4'd0,  16'h0000},
        '{OP_IDLE, 2'd0, 4'd0,  16'd10},
        '{OP_PIN,  2'd0, 4'd3,  16'h0005},
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_SPAN, 2'd0, 4'd3,  16'd18},    // R3 period of 18 cycles
        '{OP_WR,   2'd2, 4'd7,  16'h000F},
        '{OP_WR,   2'd3, 4'd2,  16'h0001},  // A rising, B falling
        '{OP_PIN,  2'd0, 4'd0,  16'h0000},
        '{OP_IDLE, 2'd0, 4'd0,  16'd3},
        '{OP_PIN,  2'd0, 4'd2,  16'h0007},  // both high, A active
        '{OP_IDLE, 2'd0, 4'd0,  16'd6},
        '{OP_PIN,  2'd0, 4'd2,  16'h0008},  // both low, B active
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_SPAN, 2'd1, 4'd3,  16'd7},     // R3 pulse width of 7 cycles
        '{OP_CAP,  2'd1, 4'd2,  16'h0000},  // R2 falling capture on B
        '{OP_WR,   2'd2, 4'd7,  16'h000F},
        '{OP_WR,   2'd3, 4'd5,  16'h0003},
        '{OP_PIN,  2'd0, 4'd5,  16'h0005},
        '{OP_IDLE, 2'd0, 4'd0,  16'd3},
        '{OP_CHK,  2'd2, 4'd5,  16'h0001},  // R5 A first, B untouched
        '{OP_PIN,  2'd0, 4'd5,  16'h000B},
        '{OP_IDLE, 2'd0, 4'd0,  16'd4},
        '{OP_CHK,  2'd2, 4'd5,  16'h0005},  // R5 both flags
        '{OP_CAP,  2'd1, 4'd5,  16'h0000},  // R5 B capture
        '{OP_IRQ,  2'd0, 4'd9,  16'h0000},  // R9 flags set, enables off
        '{OP_WR,   2'd3, 4'd10, 16'h0007},
        '{OP_IRQ,  2'd0, 4'd10, 16'h0001},  // R10 late enable raises irq
        '{OP_WR,   2'd2, 4'd10, 16'h0001},
        '{OP_IRQ,  2'd0, 4'd10, 16'h0000},  // R10 cleared flag drops irq
        '{OP_WR,   2'd3, 4'd10, 16'h000B},
        '{OP_IRQ,  2'd0, 4'd10, 16'h0001},  // R10 B enable
        '{OP_CMP,  2'd0, 4'd8,  16'h0000},
        '{OP_CHK,  2'd2, 4'd8,  16'h0024},  // R8 compare flag
        '{OP_CMP,  2'd0, 4'd7,  16'h0001},  // event with same-cycle clear
        '{OP_CHK,  2'd2, 4'd7,  16'h0024},  // R7 event wins
        '{OP_WR,   2'd2, 4'd7,  16'h0020},
        '{OP_WR,   2'd3, 4'd10, 16'h0023},
        '{OP_IRQ,  2'd0, 4'd10, 16'h0000},
        '{OP_CMP,  2'd0, 4'd10, 16'h0000},
        '{OP_IRQ,  2'd0, 4'd10, 16'h0001}   // R10 compare interrupt
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cap_pin_a, cap_pin_b, cmp_evt, reg_wr, irq;
    logic [1:0]  reg_addr;
    logic [6:0]  reg_wdata;
    logic [15:0] reg_rdata;
    logic [15:0] mcnt, rec_a, rec_b, saved_a;
    int          checks = 0;
    int          fails  = 0;

    always #10 clk = ~clk;

    cap_timer i_cap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pin_a (cap_pin_a),
        .cap_pin_b (cap_pin_b),
        .cmp_evt   (cmp_evt),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Expected time base per R1
    always @(posedge clk) begin
        if (!rst_n) mcnt <= 16'hFFFF;
        else        mcnt <= mcnt - 16'd1;
    end

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(input vec_t v);
        logic [15:0] d, db;
        case (v.op)
            OP_WR: begin
                reg_addr = v.arg; reg_wdata = v.val[6:0]; reg_wr = 1'b1;
                @(negedge clk);
                reg_wr = 1'b0;
            end
            OP_PIN: begin
                cap_pin_a = v.val[0];
                cap_pin_b = v.val[1];
                if (v.val[2]) rec_a = mcnt;
                if (v.val[3]) rec_b = mcnt;
                @(negedge clk);
            end
            OP_IDLE: repeat (int'(v.val)) @(negedge clk);
            OP_CHK: begin
                rd(v.arg, d);
                chk(int'(v.req), d, v.val);
                @(negedge clk);
            end
            OP_CAP: begin
                rd(v.arg, d);
                chk(int'(v.req), d, ((v.arg == 2'd0) ? rec_a : rec_b) - 16'd2);
                if (v.arg == 2'd0) saved_a = d;
                @(negedge clk);
            end
            OP_SPAN: begin
                rd(2'd0, d);
                if (v.arg == 2'd0) chk(int'(v.req), saved_a - d, v.val);
                else begin
                    rd(2'd1, db);
                    chk(int'(v.req), d - db, v.val);
                end
                @(negedge clk);
            end
            OP_IRQ: begin
                #1;
                chk(int'(v.req), {15'b0, irq}, v.val);
                @(negedge clk);
            end
            default: begin
                cmp_evt = 1'b1;
                if (v.val[0]) begin
                    reg_addr = 2'd2; reg_wdata = 7'h20; reg_wr = 1'b1;
                end
                @(negedge clk);
                cmp_evt = 1'b0;
                reg_wr  = 1'b0;
            end
        endcase
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; cap_pin_a = 1'b0; cap_pin_b = 1'b0; cmp_evt = 1'b0;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        rec_a = '0; rec_b = '0; saved_a = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) step(VECS[i]);

        // Counter wrap: zero then overflow flag, capture across the wrap (R1, R8)
        step('{OP_WR, 2'd2, 4'd7, 16'h007F});
        step('{OP_WR, 2'd3, 4'd10, 16'h0053});
        cap_pin_a = 1'b0;
        @(negedge clk);
        while (mcnt != 16'h0001) @(negedge clk);
        cap_pin_a = 1'b1;
        rec_a = mcnt;
        @(negedge clk);
        rd(2'd2, d);
        chk(8, d & 16'h0050, 16'h0040);           // R8 zero flag, no overflow yet
        chk(10, {15'b0, irq}, 16'h0001);          // R10 zero interrupt
        @(negedge clk);
        rd(2'd2, d);
        chk(8, d & 16'h0050, 16'h0050);           // R8 overflow one cycle later
        repeat (3) @(negedge clk);
        rd(2'd0, d);
        chk(1, d, 16'hFFFF);                      // R1 capture across wrap
        chk(1, rec_a - 16'd2, 16'hFFFF);

        // Mid-run reset (R11), then counter restart seen through a capture (R1)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, d); chk(11, d, 16'h0000);
        rd(2'd3, d); chk(11, d, 16'h0000);
        rd(2'd0, d); chk(11, d, 16'h0000);
        rd(2'd1, d); chk(11, d, 16'h0000);
        chk(11, {15'b0, irq}, 16'h0000);
        @(negedge clk);
        cap_pin_a = 1'b0;                         // falling is active after reset
        rec_a = mcnt;
        repeat (4) @(negedge clk);
        rd(2'd0, d);
        chk(1, d, rec_a - 16'd2);                 // R1 restart from all-ones
        rd(2'd2, d);
        chk(2, d, 16'h0001);                      // R2 falling selected by 0
        finish_run();
    end

endmodule